// File: doc/BRIEF.md
# I2C Bus Hang Recovery Sequencer

This block watches a two-wire bus and clears a hang in which a target device keeps the data line low. It samples the clock and data lines and reports both levels as status. It also keeps a bus-busy flag, which it follows from the START and STOP conditions seen on the wires. When software issues a recovery command and the data line reads low, the block clocks SCL. It produces a bounded train of pulses, paced by an external half-period tick, and stops as soon as the data line is seen released.

Once the data line has been released, the block drives a clean STOP so that every device on the bus returns to idle. At the end of every recovery attempt, whether it succeeded or not, it raises a sticky completion interrupt flag. Software clears that flag by writing a one to it. A failed attempt can be told apart from a successful one because the data-line status bit still reads low afterwards. Both line drives are open-drain pull-down enables. The inputs are assumed to be already synchronized to the block clock.

Top module: `i2c_hang_recovery`

## Requirements
- R1: After a synchronous reset, both drive outputs are 0 (lines released), the busy flag is 0 and the completion flag is 0.
- R2: `stat_scl` and `stat_sda` show the levels of `scl_in` and `sda_in` as sampled one clock earlier.
- R3: `stat_busy` is set after SDA falls while SCL stays high (START) and is cleared after SDA rises while SCL stays high (STOP).
- R4: A recovery command issued while the sampled SDA is high is ignored: no SCL pulse is produced and the completion flag is not set.
- R5: During the pulse train, SCL is pulled low until the next tick and then released for one full tick interval. SDA is never driven during the train.
- R6: SDA is tested at the end of each SCL high phase. The train stops at the first high reading, so a target that lets go during the K-th high phase sees exactly K pulses.
- R7: The train has at most MAX_PULSES (default 8) pulses. If SDA is still low after the last one, the completion flag is still set, no STOP is driven and `stat_sda` stays 0.
- R8: After a successful train, the block drives a STOP in four steps of one tick each: SCL low, then SDA low, then SCL released, then SDA released. This makes the busy flag clear.
- R9: `irq_done` is set when a recovery attempt ends.
- R10: `irq_done` stays set until a cycle with `done_clear` high, after which it reads 0.
- R11: A recovery command that arrives while an attempt is in progress has no effect on the number of pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| recover_cmd | input | 1 | One-cycle recovery command pulse |
| half_tick | input | 1 | One-cycle pulse per SCL half period |
| done_clear | input | 1 | Write-one-to-clear strobe for the completion flag |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| stat_scl | output | 1 | Sampled SCL level |
| stat_sda | output | 1 | Sampled SDA level |
| stat_busy | output | 1 | Bus busy between START and STOP |
| irq_done | output | 1 | Sticky recovery-complete flag |

## Verification
The bench models a target that holds SDA low for a chosen number of SCL rising edges. It counts the edges at the wire, using release points of one pulse, a few pulses, exactly the limit, and beyond the limit. A design with an off-by-one stop test would show one pulse too many or too few. A design without the cap would keep clocking on the stuck case, and one that skipped the STOP would leave the busy flag set after a success. The bench also issues the command on an idle bus, where a faulty design would toggle SCL or raise the flag. It repeats the command in the middle of a train, where a design that restarts its count would deliver extra pulses. Finally, it clears the flag and checks that the flag reads 0 afterwards.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_STP_PRE,
        ST_STP_SDA,
        ST_STP_SCL,
        ST_FIN
    } rcv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } bus_drive_t;

    localparam bus_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

    function automatic logic is_start(bus_lines_t prev, bus_lines_t cur);
        return prev.scl && cur.scl && prev.sda && !cur.sda;
    endfunction

    function automatic logic is_stop(bus_lines_t prev, bus_lines_t cur);
        return prev.scl && cur.scl && !prev.sda && cur.sda;
    endfunction

    function automatic bus_drive_t drive_for(rcv_state_e s);
        bus_drive_t d;
        d.scl_low = (s == ST_CLK_LO) || (s == ST_STP_PRE) || (s == ST_STP_SDA);
        d.sda_low = (s == ST_STP_SDA) || (s == ST_STP_SCL);
        return d;
    endfunction

endpackage

// File: rtl/rcv_line_monitor.sv
module rcv_line_monitor
    import i2c_rcv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t lines_in,
    output bus_lines_t lines_q,
    output logic       busy
);
    bus_lines_t prev_q;
    logic       start_seen;
    logic       stop_seen;

    assign start_seen = is_start(prev_q, lines_q);
    assign stop_seen  = is_stop(prev_q, lines_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= LINES_IDLE;
            prev_q  <= LINES_IDLE;
            busy    <= 1'b0;
        end else begin
            lines_q <= lines_in;
            prev_q  <= lines_q;
            if (start_seen)
                busy <= 1'b1;
            else if (stop_seen)
                busy <= 1'b0;
        end
    end

    // R3: no START or STOP can happen while SCL is held low
    assert_busy_steady_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!lines_q.scl && !prev_q.scl) |=> $stable(busy));

endmodule

// File: rtl/rcv_pulse_seq.sv
module rcv_pulse_seq
    import i2c_rcv_pkg::*;
#(
    parameter int MAX_PULSES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd,
    input  bus_lines_t lines,
    output bus_drive_t drv,
    output logic       done_pulse
);
    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

    rcv_state_e      st;
    rcv_state_e      st_nx;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_plus;

    assign cnt_plus = cnt + CW'(1);

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:    if (cmd && !lines.sda) st_nx = ST_CLK_LO;
            ST_CLK_LO:  if (tick) st_nx = ST_CLK_HI;
            ST_CLK_HI: begin
                if (tick) begin
                    if (lines.sda)
                        st_nx = ST_STP_PRE;
                    else if (cnt_plus == LIMIT)
                        st_nx = ST_FIN;
                    else
                        st_nx = ST_CLK_LO;
                end
            end
            ST_STP_PRE: if (tick) st_nx = ST_STP_SDA;
            ST_STP_SDA: if (tick) st_nx = ST_STP_SCL;
            ST_STP_SCL: if (tick) st_nx = ST_FIN;
            ST_FIN:     st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE)
                cnt <= '0;
            else if (st == ST_CLK_HI && tick)
                cnt <= cnt_plus;
        end
    end

    assign drv        = drive_for(st);
    assign done_pulse = (st == ST_FIN);

    // R4: command on a released data line leaves the sequencer idle
    assert_idle_cmd_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cmd && lines.sda) |=> (st == ST_IDLE));

    // R7: pulse count never passes the limit
    assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    // R8: SDA is only pulled while SCL is low
    assert_sda_pull_under_low_scl_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.sda_low) |-> drv.scl_low);

    // R8: SDA is released with SCL high, forming a STOP
    assert_sda_release_is_stop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.sda_low) |-> !drv.scl_low);

    // R5: data line left alone during the train
    assert_sda_free_in_train_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLK_LO || st == ST_CLK_HI) |-> !drv.sda_low);

endmodule

// File: rtl/rcv_irq_flag.sv
module rcv_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R10: a clear without a concurrent set empties the flag
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/i2c_hang_recovery.sv
module i2c_hang_recovery
    import i2c_rcv_pkg::*;
#(
    parameter int MAX_PULSES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic recover_cmd,
    input  logic half_tick,
    input  logic done_clear,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic stat_scl,
    output logic stat_sda,
    output logic stat_busy,
    output logic irq_done
);
    bus_lines_t lines_raw;
    bus_lines_t lines_q;
    bus_drive_t drv;
    logic       seq_done;

    assign lines_raw = '{scl: scl_in, sda: sda_in};

    rcv_line_monitor u_mon (
        .clk      (clk),
        .rst      (rst),
        .lines_in (lines_raw),
        .lines_q  (lines_q),
        .busy     (stat_busy)
    );

    rcv_pulse_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (half_tick),
        .cmd        (recover_cmd),
        .lines      (lines_q),
        .drv        (drv),
        .done_pulse (seq_done)
    );

    rcv_irq_flag u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (seq_done),
        .clr  (done_clear),
        .flag (irq_done)
    );

    assign scl_drive_low = drv.scl_low;
    assign sda_drive_low = drv.sda_low;
    assign stat_scl      = lines_q.scl;
    assign stat_sda      = lines_q.sda;

    // R9: the flag only rises after the sequencer ends an attempt
    assert_done_after_finish_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_done) |-> $past(seq_done));

endmodule

// File: tb/tb_i2c_hang_recovery.sv
`timescale 1ns/1ps
module tb_i2c_hang_recovery;
    localparam int MAXP = 8;
    localparam int NV   = 6;
    localparam int VK   [NV] = '{1, 2, 5, 8, 12, 3};
    localparam int VRTR [NV] = '{0, 0, 0, 0, 0, 1};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic cmd = 1'b0;
    logic clr = 1'b0;
    logic tick = 1'b0;
    int   tcnt = 0;

    logic scl_drive_low, sda_drive_low, stat_scl, stat_sda, stat_busy, irq_done;
    logic scl_line, sda_line;

    logic hold_en = 1'b0;
    int   need = 0;
    int   base = 0;
    int   seen = 0;
    logic slave_hold;

    int nchk = 0;
    int nfail = 0;

    assign slave_hold = hold_en && ((seen - base) < need);
    assign scl_line   = ~scl_drive_low;
    assign sda_line   = ~sda_drive_low & ~slave_hold;

    always @(posedge clk) begin
        if (tcnt == 3) begin
            tcnt <= 0;
            tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick <= 1'b0;
        end
    end

    always @(posedge scl_line) seen = seen + 1;

    i2c_hang_recovery #(.MAX_PULSES(MAXP)) dut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .recover_cmd   (cmd),
        .half_tick     (tick),
        .done_clear    (clr),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .stat_scl      (stat_scl),
        .stat_sda      (stat_sda),
        .stat_busy     (stat_busy),
        .irq_done      (irq_done)
    );

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic pulse_cmd();
        cmd = 1'b1;
        @(negedge clk) cmd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 scl drive after reset", scl_drive_low, 0);
        chk("R1 sda drive after reset", sda_drive_low, 0);
        chk("R1 busy after reset", stat_busy, 0);
        chk("R1 done after reset", irq_done, 0);
        chk("R2 scl status idle", stat_scl, 1);

        // R4: idle bus, command ignored
        base = seen;
        pulse_cmd();
        repeat (40) @(negedge clk);
        chk("R4 no pulses on idle bus", seen - base, 0);
        chk("R4 no done on idle bus", irq_done, 0);

        for (int v = 0; v < NV; v++) begin
            int k;
            int p;
            int ok;
            k  = VK[v];
            p  = (k < MAXP) ? k : MAXP;
            ok = (k <= MAXP) ? 1 : 0;
            base = seen;
            need = k;
            hold_en = 1'b1;
            repeat (3) @(negedge clk);
            chk("R2 sda status low when held", stat_sda, 0);
            chk("R3 busy after START", stat_busy, 1);
            pulse_cmd();
            repeat (6) @(negedge clk);
            chk("R5 sda not driven in train", sda_drive_low, 0);
            if (VRTR[v] != 0) begin
                repeat (3) @(negedge clk);
                pulse_cmd();
            end
            for (int w = 0; w < 4000 && !irq_done; w++) @(negedge clk);
            repeat (4) @(negedge clk);
            if (VRTR[v] != 0)
                chk("R11 repeated command keeps pulse count", seen - base, p + ok);
            else if (ok != 0)
                chk("R6 pulses plus STOP edge", seen - base, p + ok);
            else
                chk("R7 pulses capped, no STOP", seen - base, p);
            chk("R9 done flag set", irq_done, 1);
            chk(ok != 0 ? "R8 sda released" : "R7 sda still low", stat_sda, ok);
            chk(ok != 0 ? "R8 busy cleared by STOP" : "R7 busy kept", stat_busy, 1 - ok);
            chk("R5 scl released at end", scl_drive_low, 0);
            repeat (5) @(negedge clk);
            chk("R10 done stays set", irq_done, 1);
            clr = 1'b1;
            @(negedge clk) clr = 1'b0;
            chk("R10 done cleared", irq_done, 0);
            hold_en = 1'b0;
            repeat (3) @(negedge clk);
            chk("R3 busy cleared after release", stat_busy, 0);
            chk("R2 sda status high", stat_sda, 1);
        end

        summary();
        $finish;
    end

endmodule